// File: doc/BRIEF.md
# Pipelined byte-write SRAM core

This block is a behavioural synchronous memory array. Each word holds four 9-bit byte lanes, 36 bits in all. The lane width and lane count are parameters. A sequencer in front of the array presents a word address and a selected flag. On every rising clock edge the core decides whether the cycle is a write, a read or idle.

A global write stores every lane. A byte write needs a separate enable and stores only the lanes whose select is asserted. All write controls are active low. Any selected cycle that stores nothing is a read.

Read data is registered. It appears on the output one cycle after the edge that captured its address. The bidirectional data pins are split into a data input, a data output and a drive enable. The drive enable follows an asynchronous active-low output enable. It is also held off for two kinds of cycle: any cycle that is not the result of a read, and the first read that follows a deselected cycle.

Top module: `sram_bytewrite_core`

## Requirements
- R1: After reset, `dout_en` is low until a read has been completed.
- R2: When `gw_n` is low in a selected cycle, all lanes of the word at `addr` take `din`, whatever the values of `bwe_n` and `bs_n`. Lane k occupies bits 9k+8 down to 9k.
- R3: When `gw_n` is high and `bwe_n` is low in a selected cycle, only the lanes k whose `bs_n[k]` is low take `din[9k+8:9k]`. The other lanes keep their value.
- R4: When `gw_n` and `bwe_n` are both high, `bs_n` has no effect, no lane is written and the selected cycle is a read. A byte write with every `bs_n` bit high is also a read.
- R5: The data of a read appears on `dout` after the next rising edge. It is the word at the address sampled at the read edge.
- R6: `dout_en` is low at any time `oe_n` is high, with no clock edge needed.
- R7: If the cycle before a read edge was deselected, `dout_en` stays low for that read's output cycle, even with `oe_n` low.
- R8: A cycle with `sel` low writes nothing, and `dout_en` is low in the cycle that follows it.
- R9: A read of an address on the cycle right after a write to it returns the newly written data.
- R10: `dout_en` is low in the cycle that follows a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the control state |
| addr | input | ADDR_W | Word address |
| sel | input | 1 | Device selected for this cycle |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bs_n | input | LANES | Per-lane byte select, active low |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Registered read data |
| dout_en | output | 1 | Output drive enable |

## Verification
The assertions check the rules on `dout_en` on every cycle:
- it is gated by `oe_n`;
- it is low after a deselected cycle, after a write, and on the first read after deselection;
- a read that follows a full-word write to the same address returns that data.

Only the bench scenarios, run against a behavioural memory model, can show the lane masking of byte writes and that the array keeps its contents through deselected cycles. They also show that `bs_n` is ignored without `bwe_n` and that read data lines up with the address one cycle later.

// File: rtl/sram_bytewrite_core.sv
module sram_bytewrite_core #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sel,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [LANES-1:0]  bs_n,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);

  logic [LANES-1:0] lane_we;
  logic             rd;
  logic             rd_q, first_q, idle_q;

  assign lane_we = !sel   ? '0 :
                   !gw_n  ? '1 :
                   !bwe_n ? ~bs_n : '0;
  assign rd = sel && (lane_we == '0);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q;

    always_ff @(posedge clk) begin
      if (lane_we[k]) mem[addr] <= din[k*LANE_W +: LANE_W];
      if (rd) q <= mem[addr];
    end

    assign dout[k*LANE_W +: LANE_W] = q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q    <= 1'b0;
      first_q <= 1'b0;
      idle_q  <= 1'b1;
    end else begin
      rd_q    <= rd;
      first_q <= idle_q;
      idle_q  <= !sel;
    end
  end

  assign dout_en = !oe_n && rd_q && !first_q;

endmodule

module sram_bytewrite_core_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              sel,
  input logic              gw_n,
  input logic              bwe_n,
  input logic              oe_n,
  input logic [DATA_W-1:0] din,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en
);

  // R6
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_en);

  // R8
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !dout_en);

  // R7
  first_read_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && $past(!sel)) |=> !dout_en);

  // R10
  write_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !gw_n) |=> !dout_en);

  // R9
  write_read_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && gw_n && bwe_n && $past(sel && !gw_n) && addr == $past(addr))
      |=> (dout == $past(din, 2)));

endmodule

bind sram_bytewrite_core sram_bytewrite_core_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .sel(sel), .gw_n(gw_n), .bwe_n(bwe_n),
  .oe_n(oe_n), .din(din), .dout(dout), .dout_en(dout_en)
);

// File: tb/sram_bytewrite_core_test.sv
module sram_bytewrite_core_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [5:0]  addr = 0;
  logic        sel = 0, gw_n = 1, bwe_n = 1, oe_n = 1;
  logic [3:0]  bs_n = 4'hF;
  logic [35:0] din = 0;
  logic [35:0] dout;
  logic        dout_en;

  int tests = 0, fails = 0;

  sram_bytewrite_core uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .sel(sel), .gw_n(gw_n), .bwe_n(bwe_n),
    .bs_n(bs_n), .oe_n(oe_n), .din(din), .dout(dout), .dout_en(dout_en)
  );

  always #5 clk = ~clk;

  logic [35:0] m_mem [64];
  bit   [3:0]  m_known [64];
  logic [35:0] m_dout;
  bit   [3:0]  m_dknown;
  bit          m_rvalid, m_first, m_prev_idle = 1;

  always @(posedge clk) begin
    bit [3:0] wm;
    if (!rst_n) begin
      m_rvalid = 0; m_first = 0; m_prev_idle = 1;
    end else begin
      wm = 4'h0;
      if (sel) begin
        if (!gw_n) wm = 4'hF;
        else if (!bwe_n) wm = ~bs_n;
      end
      m_first  = m_prev_idle;
      m_rvalid = sel && wm == 0;
      m_prev_idle = !sel;
      if (m_rvalid) begin
        m_dout = m_mem[addr];
        m_dknown = m_known[addr];
      end
      for (int k = 0; k < 4; k++)
        if (wm[k]) begin
          m_mem[addr][k*9 +: 9] = din[k*9 +: 9];
          m_known[addr][k] = 1;
        end
    end
  end

  task automatic check(string tag);
    bit exp_en;
    exp_en = !oe_n && m_rvalid && !m_first;
    tests++;
    if (dout_en !== exp_en) begin
      fails++;
      $display("FAIL %s dout_en=%0b expected %0b", tag, dout_en, exp_en);
    end
    if (exp_en && m_dknown == 4'hF) begin
      tests++;
      if (dout !== m_dout) begin
        fails++;
        $display("FAIL %s dout=%h expected %h", tag, dout, m_dout);
      end
    end
  endtask

  task automatic step(bit s, int a, bit g, bit b, bit [3:0] bs, bit oe, logic [35:0] d, string tag);
    @(negedge clk);
    sel = s; addr = a[5:0]; gw_n = g; bwe_n = b; bs_n = bs; oe_n = oe; din = d;
    #1 check(tag);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seed;
    repeat (3) @(negedge clk);
    oe_n = 0;
    #1 tests++;
    if (dout_en !== 1'b0) begin
      fails++;
      $display("FAIL R1 dout_en=%0b expected 0", dout_en);
    end
    @(negedge clk);
    rst_n = 1;
    #1 check("R1");

    // R2: global write ignores bwe_n/bs_n
    step(1, 5, 0, 1, 4'hF, 0, 36'h123456789, "R2");
    step(1, 6, 0, 0, 4'h5, 0, 36'hABCDEF012, "R2");
    // R8: deselected write attempt has no effect
    step(0, 5, 0, 0, 4'h0, 0, 36'hFFFFFFFFF, "R8");
    // R7: first read after deselect masked
    step(1, 5, 1, 1, 4'hF, 0, 0, "R7");
    step(1, 5, 1, 1, 4'hF, 0, 0, "R7");
    step(1, 6, 1, 1, 4'hF, 0, 0, "R5");
    step(1, 5, 1, 1, 4'hF, 0, 0, "R5");
    // R6: oe_n high blocks drive
    step(1, 6, 1, 1, 4'hF, 1, 0, "R6");
    step(1, 6, 1, 1, 4'hF, 0, 0, "R6");
    // R3: byte writes with lane masks
    step(1, 5, 1, 0, 4'b1010, 0, 36'h000000000, "R3");
    step(1, 5, 1, 1, 4'hF, 0, 0, "R10");
    step(1, 5, 1, 1, 4'hF, 0, 0, "R3");
    step(1, 6, 1, 0, 4'b0111, 0, 36'h1FF000000, "R3");
    step(1, 6, 1, 1, 4'hF, 0, 0, "R9");
    step(1, 6, 1, 1, 4'hF, 0, 0, "R3");
    // R4: bs_n ignored without bwe_n; empty byte mask is a read
    step(1, 5, 1, 1, 4'h0, 0, 36'hFFFFFFFFF, "R4");
    step(1, 5, 1, 0, 4'hF, 0, 36'hFFFFFFFFF, "R4");
    step(1, 5, 1, 1, 4'hF, 0, 0, "R4");
    // R9: write then immediate read
    step(1, 7, 0, 1, 4'hF, 0, 36'h987654321, "R9");
    step(1, 7, 1, 1, 4'hF, 0, 0, "R10");
    step(1, 7, 1, 1, 4'hF, 0, 0, "R9");

    for (int i = 0; i < 8; i++)
      step(1, i, 0, 1, 4'hF, 0, {i[3:0], 32'h0F0F0F0F ^ i}, "R2");
    seed = 32'h1357;
    for (int i = 0; i < 400; i++) begin
      int op;
      seed = seed * 1103515245 + 12345;
      op = (seed >>> 16) & 7;
      case (op)
        0: step(0, seed[10:8], 0, 0, seed[3:0], seed[20], {seed[3:0], seed}, "R8");
        1: step(1, seed[10:8], 0, seed[4], seed[3:0], 0, {seed[7:4], seed ^ 32'h5A5A}, "R2");
        2: step(1, seed[10:8], 1, 0, seed[3:0], 0, {seed[3:0], ~seed}, "R3");
        3: step(1, seed[10:8], 1, 1, seed[3:0], 0, {seed[5:2], seed}, "R4");
        default: step(1, seed[10:8], 1, 1, 4'hF, seed[21] & seed[22], 0, "R5");
      endcase
    end
    step(0, 0, 1, 1, 4'hF, 0, 0, "R8");
    step(0, 0, 1, 1, 4'hF, 0, 0, "R8");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule